// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block turns one 128-bit plaintext block into its AES-128 ciphertext. It has one round datapath and uses it again on every clock. A single-cycle start request loads the plaintext. The block then works through ten rounds and reports the result with a one-cycle completion pulse. The ciphertext register keeps that value until the next accepted request.

Round keys come from a separate key schedule. The block drives the index of the round key it needs, and the schedule returns that key in the same cycle. While idle the index is 0, so the whitening key is already on the key input when a request arrives. The round datapath contains byte substitution, built as GF(2^8) inversion followed by the affine map, the row rotation, the column mixing and the key XOR. In the last round the column mixing is bypassed.

Top module: `aes128_iter_enc`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o` and `done_o` are 0 and `rkey_idx_o` is 0.
- R2: A `start_i` seen at a rising edge while `busy_o` is 0 is accepted. The state becomes `plain_i` XOR `rkey_i`, where `rkey_i` is the key for index 0. After that edge `busy_o` is 1 and `rkey_idx_o` is 1.
- R3: While busy, `rkey_idx_o` steps up by one per clock from 1 to 10. Round n uses the key presented on `rkey_i` while the index is n.
- R4: Rounds 1 to 9 apply byte substitution, then row rotation, then column mixing, then key XOR. Round 10 leaves out column mixing.
- R5: Byte (row r, column c) of the state sits at bits [127-8*(4c+r) -: 8]. In the row rotation, row r is rotated left by r positions. Column mixing uses the circulant matrix with first row {02,03,01,01}. Multiplying by {02} shifts the byte left by one and XORs in 0x1b when bit 7 was set.
- R6: The S-box maps 0x00 to 0x63, 0x45 to 0x6e, 0x46 to 0x5a and 0x47 to 0xa0.
- R7: `done_o` is high for exactly one cycle. It rises at the tenth rising edge after the accepting edge, and `busy_o` falls at that same edge. `cipher_o` then holds the standard AES-128 ciphertext and keeps it until the next accepted start.
- R8: A `start_i` while `busy_o` is 1 is ignored. It does not change the running block's result, and it produces no second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to encrypt `plain_i` |
| plain_i | input | 128 | Plaintext block, sampled on acceptance |
| rkey_i | input | 128 | Round key for the index on `rkey_idx_o` |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rkey_idx_o | output | 4 | Index of the round key needed this cycle |
| cipher_o | output | 128 | Ciphertext, valid from `done_o` onward |

## Verification
The encryptor is driven with three published key and plaintext pairs:
- The all-zero key and block. This shows whether the S-box constant and the whitening path are handled alone.
- The counting key 000102..0f with 00112233..ff. Every byte position differs here, so a byte-order or rotation fault shows up.
- A second irregular key and block, which stresses the field reduction in column mixing.

A start raised in the middle of a run tests that a busy block ignores requests. The S-box is also probed on its own, with inputs next to each other (0x45 to 0x47), to separate inversion faults from affine faults.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BYTE_W  = 8;
  localparam int N_ROWS  = 4;
  localparam int N_COLS  = 4;
  localparam int STATE_W = BYTE_W * N_ROWS * N_COLS;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [STATE_W-1:0] block_t;

  // multiply by {02} in GF(2^8) with the AES reduction polynomial
  function automatic byte_t gf_dbl(input byte_t b);
    byte_t r;
    r = {b[6:0], 1'b0};
    if (b[7]) r = r ^ 8'h1b;
    return r;
  endfunction

  // general GF(2^8) product by repeated doubling
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t cur;
    acc = '0;
    cur = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ cur;
      cur = gf_dbl(cur);
    end
    return acc;
  endfunction

  // inverse as a^254 by square-and-multiply; zero maps to zero
  function automatic byte_t gf_inv(input byte_t a);
    byte_t acc;
    logic [7:0] expo;
    expo = 8'd254;
    acc  = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      acc = gf_mul(acc, acc);
      if (expo[i]) acc = gf_mul(acc, a);
    end
    return acc;
  endfunction

  function automatic byte_t affine_map(input byte_t b);
    byte_t r;
    for (int i = 0; i < BYTE_W; i++) begin
      r[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
    end
    return r ^ 8'h63;
  endfunction

  function automatic int unsigned byte_lsb(input int r, input int c);
    return STATE_W - BYTE_W * (N_ROWS * c + r + 1);
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_enc_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  logic [7:0] inv_w;

  always_comb inv_w = gf_inv(byte_i);
  always_comb byte_o = affine_map(inv_w);

endmodule

// File: rtl/aes_mix_col.sv
module aes_mix_col
  import aes_enc_pkg::*;
(
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  byte_t a0, a1, a2, a3;
  byte_t d0, d1, d2, d3;

  always_comb begin
    a0 = col_i[31:24];
    a1 = col_i[23:16];
    a2 = col_i[15:8];
    a3 = col_i[7:0];
    d0 = gf_dbl(a0);
    d1 = gf_dbl(a1);
    d2 = gf_dbl(a2);
    d3 = gf_dbl(a3);
    // {03}x = {02}x ^ x
    col_o[31:24] = d0 ^ (d1 ^ a1) ^ a2 ^ a3;
    col_o[23:16] = a0 ^ d1 ^ (d2 ^ a2) ^ a3;
    col_o[15:8]  = a0 ^ a1 ^ d2 ^ (d3 ^ a3);
    col_o[7:0]   = (d0 ^ a0) ^ a1 ^ a2 ^ d3;
  end

endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_enc_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic [STATE_W-1:0] key_i,
  input  logic               last_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] sub_w;
  logic [STATE_W-1:0] shf_w;
  logic [STATE_W-1:0] mix_w;

  for (genvar g = 0; g < N_ROWS * N_COLS; g++) begin : g_sub
    aes_sbox u_sb (
      .byte_i(state_i[g*BYTE_W +: BYTE_W]),
      .byte_o(sub_w[g*BYTE_W +: BYTE_W])
    );
  end

  // row r takes its byte from column (c + r) mod 4
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
      localparam int unsigned DST = byte_lsb(r, c);
      localparam int unsigned SRC = byte_lsb(r, (c + r) % N_COLS);
      assign shf_w[DST +: BYTE_W] = sub_w[SRC +: BYTE_W];
    end
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_mix
    localparam int unsigned CLSB = STATE_W - 32 * (c + 1);
    aes_mix_col u_mc (
      .col_i(shf_w[CLSB +: 32]),
      .col_o(mix_w[CLSB +: 32])
    );
  end

  always_comb state_o = (last_i ? shf_w : mix_w) ^ key_i;

endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl #(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = $clog2(NUM_ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             step_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS);

  logic             busy_q;
  logic             done_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    accept_o = start_i && !busy_q;
    step_o   = busy_q;
    last_o   = busy_q && (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        idx_q  <= IDX_W'(1);
      end else if (last_o) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (step_o) begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes_enc_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = $clog2(NUM_ROUNDS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [STATE_W-1:0] plain_i,
  input  logic [STATE_W-1:0] rkey_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   rkey_idx_o,
  output logic [STATE_W-1:0] cipher_o
);
  // named internal events, observed by the bound checker
  logic               accept_w;
  logic               step_w;
  logic               last_w;
  logic [STATE_W-1:0] round_w;
  logic [STATE_W-1:0] state_q;

  aes_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .accept_o(accept_w),
    .step_o  (step_w),
    .last_o  (last_w),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .idx_o   (rkey_idx_o)
  );

  aes_round u_round (
    .state_i(state_q),
    .key_i  (rkey_i),
    .last_i (last_w),
    .state_o(round_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (accept_w) state_q <= plain_i ^ rkey_i;
    else if (step_w)   state_q <= round_w;
  end

  assign cipher_o = state_q;

endmodule

// File: rtl/aes128_iter_enc_chk.sv
module aes128_iter_enc_chk #(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = $clog2(NUM_ROUNDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W-1:0] rkey_idx_o,
  input logic [127:0]     cipher_o,
  input logic             accept_w,
  input logic             last_w
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS);

  assert_idle_idx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> rkey_idx_o == '0);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && rkey_idx_o == IDX_W'(1)));

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rkey_idx_o != LAST_IDX) |=>
      (busy_o && rkey_idx_o == IDX_W'($past(rkey_idx_o) + 1'b1)));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && $past(rkey_idx_o) == LAST_IDX && !busy_o));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(cipher_o));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_w);

  assert_last_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> !last_w);

endmodule

bind aes128_iter_enc aes128_iter_enc_chk #(.NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rkey_idx_o(rkey_idx_o),
  .cipher_o  (cipher_o),
  .accept_w  (accept_w),
  .last_w    (last_w)
);

// File: tb/aes128_iter_enc_test.sv
`timescale 1ns/1ps
module aes128_iter_enc_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plain = '0;
  logic [127:0] rkey;
  logic         busy, done;
  logic [3:0]   idx;
  logic [127:0] cipher;
  logic [7:0]   sb_in = '0;
  logic [7:0]   sb_out;

  int total = 0;
  int bad   = 0;

  logic [127:0] rk [0:10];
  logic [127:0] exp_q [$];

  always #2.5 clk = ~clk;

  assign rkey = (idx <= 4'd10) ? rk[idx] : '0;

  aes128_iter_enc uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .plain_i(plain),
    .rkey_i(rkey), .busy_o(busy), .done_o(done), .rkey_idx_o(idx),
    .cipher_o(cipher)
  );

  aes_sbox u_sbox_probe (.byte_i(sb_in), .byte_o(sb_out));

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side field arithmetic, written independently
  function automatic logic [7:0] t_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int k);
    return (b << k) | (b >> (8 - k));
  endfunction

  function automatic logic [7:0] t_sbox(input logic [7:0] x);
    logic [7:0] v;
    v = '0;
    for (int y = 1; y < 256; y++) if (t_mul(x, 8'(y)) == 8'h01) v = 8'(y);
    return v ^ rotl8(v,1) ^ rotl8(v,2) ^ rotl8(v,3) ^ rotl8(v,4) ^ 8'h63;
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {t_sbox(t[31:24]), t_sbox(t[23:16]), t_sbox(t[15:8]), t_sbox(t[7:0])};
        t[31:24] = t[31:24] ^ rc;
        rc = t_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  // monitor: pops expected results and checks round sequencing
  int  busy_cnt = 0;
  bit  idx_ok   = 1'b1;
  bit  prev_done = 1'b0;
  int  done_seen = 0;
  logic [127:0] last_exp = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done)
        check(!done, "R7 done lasts one cycle", 128'(done), 128'(0));
      prev_done = done;
      if (busy) begin
        busy_cnt++;
        if (idx != 4'(busy_cnt)) idx_ok = 1'b0;
      end
      if (done) begin
        done_seen++;
        check(idx_ok, "R3 index runs 1..10", 128'(idx_ok), 128'(1));
        check(busy_cnt == 10, "R7 ten busy cycles before done",
              128'(busy_cnt), 128'(10));
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected completion", cipher, '0);
        end else begin
          last_exp = exp_q.pop_front();
          check(cipher == last_exp, "R4 R5 R7 ciphertext", cipher, last_exp);
        end
        busy_cnt = 0;
        idx_ok   = 1'b1;
      end
    end
  end

  task automatic pulse_start(input logic [127:0] p);
    @(negedge clk);
    start = 1'b1;
    plain = p;
    @(negedge clk);
    start = 1'b0;
    plain = '0;
  endtask

  task automatic run_block(input logic [127:0] k, input logic [127:0] p,
                           input logic [127:0] e);
    expand(k);
    exp_q.push_back(e);
    pulse_start(p);
    check(busy && idx == 4'd1, "R2 accepted start", {busy, idx}, {1'b1, 4'd1});
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 11; r++) rk[r] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && idx == 0, "R1 state during reset",
          {busy, done, idx}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && idx == 0, "R1 state after reset",
          {busy, done, idx}, '0);

    // R6 S-box probe
    sb_in = 8'h00; #1; check(sb_out == 8'h63, "R6 sbox 00", 128'(sb_out), 128'h63);
    sb_in = 8'h45; #1; check(sb_out == 8'h6e, "R6 sbox 45", 128'(sb_out), 128'h6e);
    sb_in = 8'h46; #1; check(sb_out == 8'h5a, "R6 sbox 46", 128'(sb_out), 128'h5a);
    sb_in = 8'h47; #1; check(sb_out == 8'ha0, "R6 sbox 47", 128'(sb_out), 128'ha0);
    sb_in = 8'h53; #1; check(sb_out == t_sbox(8'h53), "R6 sbox vs bench model",
                             128'(sb_out), 128'(t_sbox(8'h53)));

    run_block(128'h000102030405060708090a0b0c0d0e0f,
              128'h00112233445566778899aabbccddeeff,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_block(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    run_block(128'h2b7e151628aed2a6abf7158809cf4f3c,
              128'h3243f6a8885a308d313198a2e0370734,
              128'h3925841d02dc09fbdc118597196a0b32);

    // R8: a second request while busy must not disturb the run
    expand(128'h000102030405060708090a0b0c0d0e0f);
    exp_q.push_back(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    pulse_start(128'h00112233445566778899aabbccddeeff);
    repeat (3) @(negedge clk);
    pulse_start(128'h3243f6a8885a308d313198a2e0370734);
    while (!done) @(negedge clk);
    repeat (15) @(negedge clk);
    check(done_seen == 4, "R8 no extra completion", 128'(done_seen), 128'(4));
    check(cipher == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R7 R8 ciphertext held",
          cipher, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check(exp_q.size() == 0, "R7 all results seen", 128'(exp_q.size()), '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule